// File: doc/BRIEF.md
# Multi-Rate Interval Timer Unit

This block keeps time for a small controller. One base tick is divided down from the system clock, and every timer in the unit is built on that tick. There are two fixed interval timers. Each one picks its period from a short menu of four entries, and the longest entry differs between the two timers. There are also two programmable 8-bit down-counters, and each of them counts one of three tick rates. A slow flag is set once per long interval and stays set until software clears it. Each of the four timers sends a one-cycle interrupt pulse when it expires. The slow flag sends a one-cycle event pulse each time it is set, and a halt controller outside the block can use that pulse as a wake-up.

The prescaler first divides the clock by `BASE_DIV` to make the base tick, which is 10 µs at the default settings. Two cascaded dividers, each of ratio `DECADE`, then make the middle tick (100 µs) and the slow tick (1 ms). The slow flag is set after `FF_MS` slow ticks. Interrupt arbitration and the CPU halt logic are not part of this block.

Top module: `mrt_timer_unit`

## Requirements
- R1: The base tick comes after every `BASE_DIV` clocks. With reset released, the tick falls in clock cycle k (counted from 0) when k mod `BASE_DIV` = `BASE_DIV`-1. Fixed timer 0 with select code 0 expires on every base tick.
- R2: Fixed timer 0 has four select codes. Codes 0, 1, 2 and 3 give periods of 1, `DECADE`, `DECADE`² and 5·`DECADE`² base ticks (10 µs, 100 µs, 1 ms and 5 ms at the defaults). Its interrupt is `irq[0]`.
- R3: Fixed timer 1 uses the same codes 0 to 2 as timer 0. Its code 3 gives 10·`DECADE`² base ticks (10 ms). Its interrupt is `irq[1]`.
- R4: When a fixed timer's select changes, the count starts again from zero, and no interrupt comes out in the cycle after the change.
- R5: A programmable timer counts a tick chosen by its clock code: 0 for the base tick, 1 for the middle tick (every `DECADE` base ticks), 2 for the slow tick (every `DECADE`² base ticks), and 3 to stop. It expires every reload+1 selected ticks and then reloads. Timer 2 drives `irq[2]` and timer 3 drives `irq[3]`.
- R6: When a programmable timer's reload value or clock code changes, its counter is loaded with the new reload value, and no interrupt comes out in the cycle after the change.
- R7: A reload value of zero makes the programmable timer expire on every selected tick.
- R8: The slow flag is set once every `FF_MS` slow ticks. `tff_evt` pulses in the same cycle in which `tff_flag` goes high.
- R9: Once the slow flag is set, it stays set until `tff_clr` is high at a clock edge. A clear that arrives with no set lowers the flag.
- R10: If a set and a clear reach the flag at the same edge, the flag ends up set.
- R11: During reset and straight after it, every interrupt output, `tff_flag` and `tff_evt` are low.
- R12: Each interrupt output is high for one cycle at a time and never for two cycles in a row. This holds when `BASE_DIV` ≥ 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| fx0_sel | input | 2 | Period code of fixed timer 0 |
| fx1_sel | input | 2 | Period code of fixed timer 1 |
| pg2_sel | input | 2 | Clock code of programmable timer 2 |
| pg2_reload | input | PW | Reload value of programmable timer 2 |
| pg3_sel | input | 2 | Clock code of programmable timer 3 |
| pg3_reload | input | PW | Reload value of programmable timer 3 |
| tff_clr | input | 1 | Clears the slow flag |
| irq | output | 4 | Expiry pulses; bits 0 and 1 are the fixed timers, bits 2 and 3 the programmable timers |
| tff_flag | output | 1 | Sticky slow flag |
| tff_evt | output | 1 | One-cycle pulse each time the slow flag is set |

## Verification
A fault in the prescaler or in a decade divider moves every later interrupt in time, and the per-cycle comparison catches the first pulse that is early or late. A stale counter inside a timer shows up at its first expiry after a select change or a reload change, within one period. A stale slow-flag counter first shows up after a full slow interval has passed. A wrong set-versus-clear priority shows up only in the one cycle where both strobes meet, so the stimulus forces that meeting on purpose.

// File: rtl/mrt_pkg.sv
package mrt_pkg;

    typedef enum logic [1:0] {
        PG_BASE = 2'd0,
        PG_MID  = 2'd1,
        PG_SLOW = 2'd2,
        PG_STOP = 2'd3
    } pg_clk_e;

    typedef struct packed {
        logic base;
        logic mid;
        logic slow;
    } tick_s;

    // Length of a fixed-timer period in base ticks.
    function automatic int unsigned fx_period(input logic [1:0] code,
                                              input bit long_menu,
                                              input int unsigned dec);
        case (code)
            2'd0:    return 1;
            2'd1:    return dec;
            2'd2:    return dec * dec;
            default: return long_menu ? 10 * dec * dec : 5 * dec * dec;
        endcase
    endfunction

endpackage

// File: rtl/mrt_prescaler.sv
module mrt_prescaler
    import mrt_pkg::*;
#(
    parameter int unsigned BASE_DIV = 45,
    parameter int unsigned DECADE   = 10
) (
    input  logic  clk,
    input  logic  rst,
    output tick_s ticks
);
    localparam int unsigned BW = $clog2(BASE_DIV + 1);
    localparam int unsigned DW = $clog2(DECADE + 1);

    logic [BW-1:0] base_cnt;
    logic [DW-1:0] mid_cnt;
    logic [DW-1:0] slow_cnt;

    always_comb begin
        ticks.base = (base_cnt == BW'(BASE_DIV - 1));
        ticks.mid  = ticks.base && (mid_cnt == DW'(DECADE - 1));
        ticks.slow = ticks.mid && (slow_cnt == DW'(DECADE - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_cnt <= '0;
            mid_cnt  <= '0;
            slow_cnt <= '0;
        end else begin
            base_cnt <= ticks.base ? '0 : base_cnt + 1'b1;
            if (ticks.base)
                mid_cnt <= ticks.mid ? '0 : mid_cnt + 1'b1;
            if (ticks.mid)
                slow_cnt <= ticks.slow ? '0 : slow_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mrt_fixed.sv
module mrt_fixed
    import mrt_pkg::*;
#(
    parameter int unsigned DECADE    = 10,
    parameter bit          LONG_MENU = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       base_tick,
    input  logic [1:0] sel,
    output logic       irq
);
    localparam int unsigned CW = $clog2(10 * DECADE * DECADE + 1);

    logic [1:0]    sel_q;
    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    always_comb last = CW'(fx_period(sel, LONG_MENU, DECADE) - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            cnt   <= '0;
            irq   <= 1'b0;
        end else begin
            irq   <= 1'b0;
            sel_q <= sel;
            if (sel != sel_q) begin
                cnt <= '0;
            end else if (base_tick) begin
                if (cnt == last) begin
                    cnt <= '0;
                    irq <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mrt_prog.sv
module mrt_prog
    import mrt_pkg::*;
#(
    parameter int unsigned PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  tick_s         ticks,
    input  logic [1:0]    sel,
    input  logic [PW-1:0] reload,
    output logic          irq
);
    logic [1:0]    sel_q;
    logic [PW-1:0] rel_q;
    logic [PW-1:0] cnt;
    logic          tk;

    always_comb begin
        case (pg_clk_e'(sel))
            PG_BASE: tk = ticks.base;
            PG_MID:  tk = ticks.mid;
            PG_SLOW: tk = ticks.slow;
            default: tk = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            rel_q <= '0;
            cnt   <= '0;
            irq   <= 1'b0;
        end else begin
            irq   <= 1'b0;
            sel_q <= sel;
            rel_q <= reload;
            if (sel != sel_q || reload != rel_q) begin
                cnt <= reload;
            end else if (tk) begin
                if (cnt == '0) begin
                    cnt <= reload;
                    irq <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mrt_timer_unit.sv
module mrt_timer_unit
    import mrt_pkg::*;
#(
    parameter int unsigned BASE_DIV = 45,
    parameter int unsigned DECADE   = 10,
    parameter int unsigned FF_MS    = 125,
    parameter int unsigned PW       = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    fx0_sel,
    input  logic [1:0]    fx1_sel,
    input  logic [1:0]    pg2_sel,
    input  logic [PW-1:0] pg2_reload,
    input  logic [1:0]    pg3_sel,
    input  logic [PW-1:0] pg3_reload,
    input  logic          tff_clr,
    output logic [3:0]    irq,
    output logic          tff_flag,
    output logic          tff_evt
);
    localparam int unsigned NFX = 2;
    localparam int unsigned NPG = 2;
    localparam int unsigned MW  = $clog2(FF_MS + 1);

    tick_s         ticks;
    logic [1:0]    fx_sel_a [NFX];
    logic [1:0]    pg_sel_a [NPG];
    logic [PW-1:0] pg_rel_a [NPG];
    logic [MW-1:0] ms_cnt;
    logic          ff_wrap;

    assign fx_sel_a[0] = fx0_sel;
    assign fx_sel_a[1] = fx1_sel;
    assign pg_sel_a[0] = pg2_sel;
    assign pg_sel_a[1] = pg3_sel;
    assign pg_rel_a[0] = pg2_reload;
    assign pg_rel_a[1] = pg3_reload;

    mrt_prescaler #(.BASE_DIV(BASE_DIV), .DECADE(DECADE)) u_pre (
        .clk(clk), .rst(rst), .ticks(ticks)
    );

    for (genvar i = 0; i < NFX; i++) begin : g_fx
        mrt_fixed #(.DECADE(DECADE), .LONG_MENU(i == 1)) u_fx (
            .clk(clk), .rst(rst), .base_tick(ticks.base),
            .sel(fx_sel_a[i]), .irq(irq[i])
        );
    end

    for (genvar j = 0; j < NPG; j++) begin : g_pg
        mrt_prog #(.PW(PW)) u_pg (
            .clk(clk), .rst(rst), .ticks(ticks),
            .sel(pg_sel_a[j]), .reload(pg_rel_a[j]), .irq(irq[NFX + j])
        );
    end

    assign ff_wrap = ticks.slow && (ms_cnt == MW'(FF_MS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            ms_cnt   <= '0;
            tff_evt  <= 1'b0;
            tff_flag <= 1'b0;
        end else begin
            tff_evt  <= ff_wrap;
            if (ticks.slow)
                ms_cnt <= ff_wrap ? '0 : ms_cnt + 1'b1;
            tff_flag <= ff_wrap | (tff_flag & ~tff_clr);
        end
    end
endmodule

// File: rtl/mrt_timer_unit_chk.sv
module mrt_timer_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] fx0_sel,
    input logic [1:0] pg2_sel,
    input logic [1:0] pg3_sel,
    input logic       tff_clr,
    input logic [3:0] irq,
    input logic       tff_flag,
    input logic       tff_evt
);
    // R12: no interrupt line stays high for two cycles
    p_irq_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        (irq & $past(irq)) == 4'b0000);

    // R4: after a select change, fixed timer 0 is silent for one cycle
    p_fx_restart_r4: assert property (@(posedge clk) disable iff (rst)
        (fx0_sel != $past(fx0_sel)) |=> !irq[0]);

    // R5: a stopped programmable timer does not expire
    p_pg2_stop_r5: assert property (@(posedge clk) disable iff (rst)
        (pg2_sel == 2'd3) |=> !irq[2]);
    p_pg3_stop_r5: assert property (@(posedge clk) disable iff (rst)
        (pg3_sel == 2'd3) |=> !irq[3]);

    // R8: the event pulse comes with the flag
    p_tff_evt_r8: assert property (@(posedge clk) disable iff (rst)
        tff_evt |-> tff_flag);

    // R9: the flag holds while there is no clear
    p_tff_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (tff_flag && !tff_clr) |=> tff_flag);

    // R10: after a clear the flag is high only if a set came at the same edge
    p_tff_clear_r10: assert property (@(posedge clk) disable iff (rst)
        tff_clr |=> (tff_flag == tff_evt));
endmodule

bind mrt_timer_unit mrt_timer_unit_chk u_chk (
    .clk(clk), .rst(rst), .fx0_sel(fx0_sel), .pg2_sel(pg2_sel),
    .pg3_sel(pg3_sel), .tff_clr(tff_clr), .irq(irq),
    .tff_flag(tff_flag), .tff_evt(tff_evt)
);

// File: tb/mrt_timer_unit_tb.sv
module mrt_timer_unit_tb;
    localparam int B     = 2;
    localparam int D     = 10;
    localparam int FFMS  = 125;
    localparam int PW    = 8;
    localparam int NCYC  = 80000;

    logic          clk = 1'b0;
    logic          rst;
    logic [1:0]    fx0_sel, fx1_sel, pg2_sel, pg3_sel;
    logic [PW-1:0] pg2_reload, pg3_reload;
    logic          tff_clr;
    logic [3:0]    irq;
    logic          tff_flag, tff_evt;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    mrt_timer_unit #(.BASE_DIV(B), .DECADE(D), .FF_MS(FFMS), .PW(PW)) u_dut (
        .clk(clk), .rst(rst), .fx0_sel(fx0_sel), .fx1_sel(fx1_sel),
        .pg2_sel(pg2_sel), .pg2_reload(pg2_reload),
        .pg3_sel(pg3_sel), .pg3_reload(pg3_reload),
        .tff_clr(tff_clr), .irq(irq), .tff_flag(tff_flag), .tff_evt(tff_evt)
    );

    // reference state
    int k;
    int fcnt [2];
    int fsq  [2];
    int pcnt [2];
    int psq  [2];
    int prq  [2];
    int msc;
    logic [3:0] e_irq;
    logic       e_flag, e_evt;
    string      tag [4];
    string      ftag;
    logic [3:0] prev_irq;
    int         sets_seen;
    int         since_set;

    function automatic int ref_period(input int code, input bit long_menu);
        if (code == 0) return 1;
        if (code == 1) return D;
        if (code == 2) return D * D;
        return long_menu ? 10 * D * D : 5 * D * D;
    endfunction

    function automatic bit tk_base(input int c); return (c % B) == B - 1; endfunction
    function automatic bit tk_mid(input int c);  return (c % (B * D)) == B * D - 1; endfunction
    function automatic bit tk_slow(input int c); return (c % (B * D * D)) == B * D * D - 1; endfunction

    task automatic chk(input string t, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s at cycle %0d: got %0b expected %0b", t, k, act, exp);
        end
    endtask

    task automatic model_step();
        int fs [2];
        int ps [2];
        int pr [2];
        bit tk;
        bit wrap;
        fs[0] = fx0_sel; fs[1] = fx1_sel;
        ps[0] = pg2_sel; ps[1] = pg3_sel;
        pr[0] = pg2_reload; pr[1] = pg3_reload;
        for (int i = 0; i < 2; i++) begin
            e_irq[i] = 1'b0;
            tag[i] = (i == 0) ? ((fs[0] == 0) ? "R1" : "R2") : "R3";
            if (fs[i] != fsq[i]) begin
                fcnt[i] = 0; fsq[i] = fs[i]; tag[i] = "R4";
            end else if (tk_base(k)) begin
                if (fcnt[i] == ref_period(fs[i], i == 1) - 1) begin
                    fcnt[i] = 0; e_irq[i] = 1'b1;
                end else fcnt[i]++;
            end
        end
        for (int j = 0; j < 2; j++) begin
            e_irq[2 + j] = 1'b0;
            tag[2 + j] = (pr[j] == 0) ? "R7" : "R5";
            tk = (ps[j] == 0) ? tk_base(k) : (ps[j] == 1) ? tk_mid(k) :
                 (ps[j] == 2) ? tk_slow(k) : 1'b0;
            if (ps[j] != psq[j] || pr[j] != prq[j]) begin
                pcnt[j] = pr[j]; psq[j] = ps[j]; prq[j] = pr[j]; tag[2 + j] = "R6";
            end else if (tk) begin
                if (pcnt[j] == 0) begin
                    pcnt[j] = pr[j]; e_irq[2 + j] = 1'b1;
                end else pcnt[j]--;
            end
        end
        wrap = tk_slow(k) && (msc == FFMS - 1);
        if (tk_slow(k)) msc = wrap ? 0 : msc + 1;
        ftag = (wrap && tff_clr) ? "R10" : "R9";
        e_evt  = wrap;
        e_flag = wrap | (e_flag & ~tff_clr);
        k++;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1;
        fx0_sel = 2'd0; fx1_sel = 2'd0; pg2_sel = 2'd0; pg3_sel = 2'd0;
        pg2_reload = '0; pg3_reload = '0; tff_clr = 1'b0;
        k = 0; msc = 0; e_flag = 0; e_evt = 0; e_irq = '0; prev_irq = '0;
        sets_seen = 0; since_set = -1; ftag = "R9";
        for (int i = 0; i < 2; i++) begin
            fcnt[i] = 0; fsq[i] = 0; pcnt[i] = 0; psq[i] = 0; prq[i] = 0;
        end
        for (int i = 0; i < 4; i++) tag[i] = "R11";
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R11 irq in reset", |irq, 1'b0);
        chk("R11 flag in reset", tff_flag, 1'b0);
        chk("R11 evt in reset", tff_evt, 1'b0);
        rst = 1'b0;
        for (int c = 0; c < NCYC; c++) begin
            if (c > 0) begin
                for (int i = 0; i < 4; i++) chk(tag[i], irq[i], e_irq[i]);
                chk("R8 evt", tff_evt, e_evt);
                chk(ftag, tff_flag, e_flag);
                chk("R12 back-to-back irq", |(irq & prev_irq), 1'b0);
                if (e_evt) begin sets_seen++; since_set = 0; end
                else if (since_set >= 0) since_set++;
            end
            prev_irq = irq;
            // stimulus: directed phase first, then random
            if (c == 0) begin
                fx0_sel = 2'd0; fx1_sel = 2'd1; pg2_sel = 2'd0; pg2_reload = 8'd0;
                pg3_sel = 2'd1; pg3_reload = 8'd3;
            end else if (c == 3000) begin
                fx0_sel = 2'd3; fx1_sel = 2'd3; pg2_sel = 2'd3; pg3_sel = 2'd2;
            end else if (c > 12000) begin
                if ($urandom % 1500 == 0) fx0_sel = 2'($urandom % 4);
                if ($urandom % 1500 == 0) fx1_sel = 2'($urandom % 4);
                if ($urandom % 1200 == 0) pg2_sel = 2'($urandom % 4);
                if ($urandom % 1200 == 0) pg3_sel = 2'($urandom % 4);
                if ($urandom % 900 == 0)
                    pg2_reload = ($urandom % 8 == 0) ? 8'($urandom) : 8'($urandom % 16);
                if ($urandom % 900 == 0) pg3_reload = 8'($urandom % 16);
            end
            // clear strobe: a plain clear after the first set, a colliding one at the second
            tff_clr = 1'b0;
            if (sets_seen == 1 && since_set == 500) tff_clr = 1'b1;
            if (sets_seen == 1 && tk_slow(k) && msc == FFMS - 1) tff_clr = 1'b1;
            if (sets_seen == 2 && since_set == 300) tff_clr = 1'b1;
            model_step();
            @(negedge clk);
        end
        if (sets_seen < 2) begin
            n_chk++; n_err++;
            $display("FAIL R8 too few flag sets: got %0d expected >=2", sets_seen);
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule